// File: doc/BRIEF.md
# Byte-Link Round Guard with Timeout Recovery

This block sequences one end of a byte link between two boards. Traffic moves in rounds. A round is a fixed number of data bytes, and an idle gap separates one round from the next. The receive sequencer collects the bytes of a round from a strobed byte input. When the last byte arrives, it presents the assembled round together with a one-cycle completion pulse. The transmit sequencer sends a round of the same length once a new round is requested and the link has stayed quiet for long enough.

A countdown timer guards the receive sequencer. The timer is reloaded at every cycle in which the receiver is idle between rounds, and it runs down while a round is being collected. If a round does not finish before the timer runs out, the block raises a one-cycle fault. The fault returns the receiver to idle and cuts off any transmission in progress. Both ends of the link then land back at the idle point between rounds, and the next round starts cleanly from its first byte.

Top module: `link_round_guard`

## Requirements
- R1: During and after a synchronous active-low reset, rx_active, round_done, fault and tx_valid are all 0, and no transmit round starts before the minimum gap has elapsed.
- R2: A byte with rx_valid high while the receiver is idle becomes byte 0 of a new round, and rx_active is 1 from the next cycle onward.
- R3: After the BYTES-th accepted byte, round_done is 1 for exactly one cycle, starting the cycle after that byte. rx_active returns to 0 in that same cycle. round_data then holds byte k of the round in bits [8k+7:8k].
- R4: Cycles with rx_valid low inside a round do not count as bytes. A round with gaps completes with the same data as the same bytes sent back to back.
- R5: Let the first byte be accepted at clock edge E0. If the round is not complete by edge E0+TIMEOUT, fault is 1 for exactly one cycle, starting after that edge. rx_active is never 1 for more than TIMEOUT consecutive cycles.
- R6: A round cut off by the timeout never produces round_done. The next accepted byte starts a new round as byte 0.
- R7: A byte presented with rx_valid high during the fault cycle is discarded. It neither starts nor joins a round.
- R8: While fault is 1, tx_valid is 0. A transmit round in progress is abandoned, and the gap count restarts from zero.
- R9: A transmit round starts only when tx_req is 1 and tx_valid has been 0 for more than MIN_GAP cycles since reset, since the end of the last round, or since a fault. A round is BYTES consecutive cycles of tx_valid with tx_index running 0, 1, … BYTES-1, and tx_last is 1 on the final cycle only.
- R10: The byte that completes a round at edge E0+TIMEOUT takes priority over expiry. round_done is raised and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_active | output | 1 | Receiver is collecting a round |
| round_done | output | 1 | One-cycle pulse when a full round has been received |
| round_data | output | BYTES*DATA_W | Assembled round; byte k in bits [DATA_W*k +: DATA_W] |
| fault | output | 1 | One-cycle pulse on round timeout |
| tx_req | input | 1 | Request to send a round |
| tx_valid | output | 1 | Transmit slot active; the source presents byte tx_index |
| tx_index | output | $clog2(BYTES) | Index of the byte being sent |
| tx_last | output | 1 | Final byte of a transmit round |

## Verification
The receiver is tried with back-to-back rounds and with rounds broken by idle cycles. This shows that only strobed cycles advance the byte count. A round that stalls after a few bytes checks the timeout, the single-cycle fault, and that no completion pulse follows. A byte placed in exactly the fault cycle, followed by a fresh round with distinct values, shows whether recovery discards the stray byte. A round whose last byte lands on the final permitted edge separates completion priority from expiry. Throughout, tx_req is held off and then held on, so that the gap rule and the cut-off on fault are both observed against a cycle-accurate model.

// File: rtl/link_round_guard_pkg.sv
// Shared state encodings for the byte-link round guard.
// Assumes: nothing beyond IEEE 1800-2017.
package link_round_guard_pkg;
    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_RECV    = 2'd1,
        RX_RECOVER = 2'd2
    } rx_state_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;
endpackage

// File: rtl/link_watchdog.sv
// Round timeout counter: reloads to TIMEOUT while run is low and counts
// down while run is high. expire marks the TIMEOUT-th cycle of a run.
// Assumes: TIMEOUT >= 2.
module link_watchdog #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    logic [TMR_W-1:0] remain;

    // Reload when idle, count down while a round is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= TMR_W'(TIMEOUT);
        else if (!run)
            remain <= TMR_W'(TIMEOUT);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expire = run && (remain == TMR_W'(1));
endmodule

// File: rtl/link_rx_seq.sv
// Receive sequencer: gathers BYTES strobed bytes into a round, pulses
// round_done on the last one, and drops to a one-cycle recovery state on
// watchdog expiry. Bytes offered during recovery are ignored.
// Assumes: BYTES >= 2; expire comes from a timer that runs while rx_active.
module link_rx_seq
    import link_round_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BYTES  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [DATA_W-1:0]       rx_byte,
    input  logic                    expire,
    output logic                    rx_active,
    output logic                    recovering,
    output logic                    round_done,
    output logic [BYTES*DATA_W-1:0] round_data
);
    localparam int IDX_W = $clog2(BYTES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    rx_state_t                      state;
    logic [IDX_W-1:0]               count;
    logic [BYTES-1:0][DATA_W-1:0]   slots;

    // Step through a round, finishing on the last byte or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            count      <= '0;
            slots      <= '0;
            round_done <= 1'b0;
        end else begin
            round_done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (rx_valid) begin
                        slots[0] <= rx_byte;
                        count    <= IDX_W'(1);
                        state    <= RX_RECV;
                    end
                end
                RX_RECV: begin
                    if (rx_valid && count == LAST) begin
                        slots[count] <= rx_byte;
                        round_done   <= 1'b1;
                        count        <= '0;
                        state        <= RX_IDLE;
                    end else begin
                        if (rx_valid) begin
                            slots[count] <= rx_byte;
                            count        <= count + 1'b1;
                        end
                        if (expire)
                            state <= RX_RECOVER;
                    end
                end
                RX_RECOVER: begin
                    count <= '0;
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign rx_active  = (state == RX_RECV);
    assign recovering = (state == RX_RECOVER);
    assign round_data = slots;
endmodule

// File: rtl/link_tx_seq.sv
// Transmit sequencer: after at least MIN_GAP idle cycles and a request,
// emits BYTES consecutive slots indexed 0..BYTES-1. abort forces idle at
// once and restarts the gap count.
// Assumes: BYTES >= 2, MIN_GAP >= 1.
module link_tx_seq
    import link_round_guard_pkg::*;
#(
    parameter int BYTES   = 8,
    parameter int MIN_GAP = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_req,
    input  logic                     abort,
    output logic                     tx_valid,
    output logic [$clog2(BYTES)-1:0] tx_index,
    output logic                     tx_last
);
    localparam int IDX_W = $clog2(BYTES);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    tx_state_t          state;
    logic [IDX_W-1:0]   idx;
    logic [GAP_W-1:0]   gap;

    // Gap counting, round start and slot stepping; abort wins.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= TX_IDLE;
            idx   <= '0;
            gap   <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_req && gap == GAP_W'(MIN_GAP)) begin
                        state <= TX_SEND;
                        idx   <= '0;
                    end else if (gap != GAP_W'(MIN_GAP)) begin
                        gap <= gap + 1'b1;
                    end
                end
                TX_SEND: begin
                    if (idx == LAST) begin
                        state <= TX_IDLE;
                        idx   <= '0;
                        gap   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign tx_valid = (state == TX_SEND) && !abort;
    assign tx_index = idx;
    assign tx_last  = tx_valid && (idx == LAST);
endmodule

// File: rtl/link_round_guard.sv
// Top of the round guard: one receive sequencer under a countdown timer,
// one transmit sequencer, and the fault path that resets both.
// Assumes: synchronous active-low reset; rx bytes arrive with a strobe.
module link_round_guard #(
    parameter int DATA_W  = 8,
    parameter int BYTES   = 8,
    parameter int TIMEOUT = 1024,
    parameter int MIN_GAP = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [DATA_W-1:0]        rx_byte,
    output logic                     rx_active,
    output logic                     round_done,
    output logic [BYTES*DATA_W-1:0]  round_data,
    output logic                     fault,
    input  logic                     tx_req,
    output logic                     tx_valid,
    output logic [$clog2(BYTES)-1:0] tx_index,
    output logic                     tx_last
);
    logic expire;

    link_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rx_active),
        .expire (expire)
    );

    link_rx_seq #(.DATA_W(DATA_W), .BYTES(BYTES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .expire     (expire),
        .rx_active  (rx_active),
        .recovering (fault),
        .round_done (round_done),
        .round_data (round_data)
    );

    link_tx_seq #(.BYTES(BYTES), .MIN_GAP(MIN_GAP)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (tx_req),
        .abort    (fault),
        .tx_valid (tx_valid),
        .tx_index (tx_index),
        .tx_last  (tx_last)
    );
endmodule

// File: rtl/link_round_guard_chk.sv
// Assertion checker for link_round_guard, attached by bind.
// Assumes: the same parameter values as the bound instance.
module link_round_guard_chk #(
    parameter int BYTES   = 8,
    parameter int TIMEOUT = 1024,
    parameter int MIN_GAP = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rx_active,
    input logic                     round_done,
    input logic                     fault,
    input logic                     tx_valid,
    input logic [$clog2(BYTES)-1:0] tx_index,
    input logic                     tx_last
);
    int act_run;
    int low_run;

    // Length of the current receive window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_run <= 0;
        else if (rx_active) act_run <= act_run + 1;
        else                act_run <= 0;
    end

    // Quiet transmit cycles since reset, last round or fault.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_run <= 0;
        else if (tx_valid || fault) low_run <= 0;
        else                        low_run <= low_run + 1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |=> !round_done);                                   // R3
    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);                                             // R5
    AST_RX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> act_run < TIMEOUT);                              // R5
    AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !round_done);                                        // R6
    AST_FAULT_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !tx_valid);                                          // R8
    AST_TX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> low_run > MIN_GAP);                        // R9
    AST_TX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_index == '0);                           // R9
    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && $past(tx_valid) && !$past(tx_last)
        |-> tx_index == $past(tx_index) + 1'b1);                       // R9
endmodule

bind link_round_guard link_round_guard_chk #(
    .BYTES   (BYTES),
    .TIMEOUT (TIMEOUT),
    .MIN_GAP (MIN_GAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_active  (rx_active),
    .round_done (round_done),
    .fault      (fault),
    .tx_valid   (tx_valid),
    .tx_index   (tx_index),
    .tx_last    (tx_last)
);

// File: tb/link_round_guard_test.sv
`timescale 1ns/1ps
module link_round_guard_test;
    localparam int DATA_W  = 8;
    localparam int BYTES   = 8;
    localparam int TIMEOUT = 40;
    localparam int MIN_GAP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_req = 1'b0;
    logic        rx_active, round_done, fault, tx_valid, tx_last;
    logic [63:0] round_data;
    logic [2:0]  tx_index;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int done_cnt = 0;
    int fault_cnt = 0;

    // reference model state
    int         m_rx = 0;     // 0 idle, 1 receiving, 2 recovery
    int         m_cnt = 0;
    int         m_el = 0;
    bit         m_done = 0;
    logic [7:0] m_buf [BYTES];
    bit         m_send = 0;
    int         m_idx = 0;
    int         m_gap = 0;

    always #2 clk = ~clk;

    link_round_guard #(.DATA_W(DATA_W), .BYTES(BYTES), .TIMEOUT(TIMEOUT),
                       .MIN_GAP(MIN_GAP)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_active(rx_active), .round_done(round_done), .round_data(round_data),
        .fault(fault), .tx_req(tx_req), .tx_valid(tx_valid),
        .tx_index(tx_index), .tx_last(tx_last)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock edge of the behavioural model.
    task automatic model_edge();
        bit f_old = (m_rx == 2);
        if (!rst_n) begin
            m_rx = 0; m_cnt = 0; m_el = 0; m_done = 0;
            m_send = 0; m_idx = 0; m_gap = 0;
            foreach (m_buf[i]) m_buf[i] = '0;
            return;
        end
        if (f_old) begin
            m_send = 0; m_idx = 0; m_gap = 0;
        end else if (!m_send) begin
            if (tx_req && m_gap >= MIN_GAP) begin m_send = 1; m_idx = 0; end
            else m_gap++;
        end else if (m_idx == BYTES - 1) begin
            m_send = 0; m_idx = 0; m_gap = 0;
        end else m_idx++;
        m_done = 0;
        case (m_rx)
            0: if (rx_valid) begin
                   m_buf[0] = rx_byte; m_cnt = 1; m_el = 0; m_rx = 1;
               end
            1: begin
                   m_el++;
                   if (rx_valid) begin
                       m_buf[m_cnt] = rx_byte;
                       if (m_cnt == BYTES - 1) begin m_done = 1; m_rx = 0; end
                       else m_cnt++;
                   end
                   if (m_rx == 1 && m_el == TIMEOUT) m_rx = 2;
               end
            default: m_rx = 0;
        endcase
    endtask

    function automatic logic [63:0] model_data();
        logic [63:0] d = '0;
        for (int k = 0; k < BYTES; k++) d[8*k +: 8] = m_buf[k];
        return d;
    endfunction

    // Drive one cycle, advance the model at the edge, compare at negedge.
    task automatic step(input bit v, input logic [7:0] b, input bit req);
        bit exp_tv;
        rx_valid = v; rx_byte = b; tx_req = req;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_tv = m_send && (m_rx != 2);
        chk("R2", "rx_active", 64'(rx_active), 64'(m_rx == 1));
        chk("R3", "round_done", 64'(round_done), 64'(m_done));
        if (m_done) chk("R3", "round_data", round_data, model_data());
        chk("R5", "fault", 64'(fault), 64'(m_rx == 2));
        chk("R9", "tx_valid", 64'(tx_valid), 64'(exp_tv));
        chk("R9", "tx_last", 64'(tx_last), 64'(exp_tv && m_idx == BYTES - 1));
        if (exp_tv) chk("R9", "tx_index", 64'(tx_index), 64'(m_idx));
        if (fault) chk("R8", "tx_valid in fault", 64'(tx_valid), 64'(0));
        if (round_done) done_cnt++;
        if (fault) fault_cnt++;
    endtask

    initial begin
        int d0, f0;
        logic [63:0] exp;
        @(negedge clk);
        step(0, 8'h00, 1); step(1, 8'h55, 1); step(0, 8'h00, 1);
        // R1: outputs idle while in reset
        chk("R1", "reset rx_active", 64'(rx_active), 0);
        chk("R1", "reset round_done", 64'(round_done), 0);
        chk("R1", "reset fault", 64'(fault), 0);
        chk("R1", "reset tx_valid", 64'(tx_valid), 0);
        rst_n = 1'b1;
        // R1/R9: no transmit without request; then gap rule after reset
        for (int i = 0; i < 20; i++) step(0, 8'h00, 0);
        chk("R1", "no tx without req", 64'(tx_valid), 0);
        // R2/R3: back-to-back round, tx_req held on
        d0 = done_cnt;
        for (int i = 0; i < BYTES; i++) step(1, 8'(8'hA0 + i), 1);
        chk("R3", "back-to-back round count", 64'(done_cnt - d0), 1);
        chk("R3", "round_data packing", round_data, 64'hA7A6A5A4A3A2A1A0);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1);
        // R4: same bytes with idle cycles between
        d0 = done_cnt;
        for (int i = 0; i < BYTES; i++) begin
            step(1, 8'(8'hA0 + i), 1);
            if (i % 2 == 0) step(0, 8'hFF, 1);
            if (i == 3) begin step(0, 8'hFF, 1); step(0, 8'hFF, 1); end
        end
        chk("R4", "gapped round count", 64'(done_cnt - d0), 1);
        chk("R4", "gapped round data", round_data, 64'hA7A6A5A4A3A2A1A0);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1);
        // R5/R6/R7: partial round, stray byte in fault cycle, fresh round
        d0 = done_cnt; f0 = fault_cnt;
        step(1, 8'h31, 1); step(1, 8'h32, 1); step(1, 8'h33, 1);
        for (int k = 3; k <= TIMEOUT; k++) step(0, 8'h00, 1);
        chk("R5", "fault after timeout", 64'(fault), 1);
        step(1, 8'hEE, 1);
        chk("R5", "fault single cycle", 64'(fault), 0);
        chk("R6", "no done on partial", 64'(done_cnt - d0), 0);
        chk("R5", "fault count", 64'(fault_cnt - f0), 1);
        chk("R7", "stray byte ignored", 64'(rx_active), 0);
        d0 = done_cnt;
        for (int i = 0; i < BYTES; i++) step(1, 8'(8'h10 + i), 1);
        exp = 64'h1716151413121110;
        chk("R6", "fresh round count", 64'(done_cnt - d0), 1);
        chk("R7", "fresh round data", round_data, exp);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1);
        // R10: last byte on the final permitted edge
        d0 = done_cnt; f0 = fault_cnt;
        step(1, 8'h60, 1);
        for (int k = 1; k <= TIMEOUT; k++) begin
            if (k < BYTES - 1)     step(1, 8'(8'h60 + k), 1);
            else if (k == TIMEOUT) step(1, 8'h67, 1);
            else                   step(0, 8'h00, 1);
        end
        chk("R10", "completion wins", 64'(round_done), 1);
        step(0, 8'h00, 1);
        chk("R10", "no fault on edge completion", 64'(fault_cnt - f0), 0);
        chk("R10", "edge round data", round_data, 64'h6766656463626160);
        // R8: repeated timeouts while the transmitter keeps cycling
        for (int r = 0; r < 4; r++) begin
            step(1, 8'h01, 1);
            for (int k = 1; k <= TIMEOUT + r; k++) step(0, 8'h00, 1);
        end
        for (int i = 0; i < 30; i++) step(0, 8'h00, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule